// File: doc/BRIEF.md
# Set-Associative Translation Cache with Pseudo-Random Replacement

This block holds recently used virtual-page to physical-frame translations. A requester presents a virtual page number with a valid strobe. In the same cycle the block reports either a hit, together with the stored frame number, or a miss. The low-order bits of the page number pick one set. Every way of that set compares its stored tag at once, and only entries marked valid take part.

On a miss, an outside agent such as a table walker fetches the translation and hands it back over the refill port. The block writes it into the indexed set. The write goes to a way that already holds the same page, if there is one. Otherwise it goes to the lowest-numbered empty way. Only when the set is full does a free-running linear-feedback shift register pick the victim. A flush strobe invalidates the whole structure at once. Two running counters record hits and misses so the hit rate can be compared against a model.

Setting the set count to one gives a fully associative cache. Setting the way count to one gives a direct-mapped cache. Both counts must be powers of two.

Top module: `tlb_rand_assoc`

## Requirements
- R1: When `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high in the same cycle, and on a hit `lk_pfn` is the stored frame; when `lk_valid` is low both are low.
- R2: The set is the low log2(SETS) bits of the page number and the tag is the remaining upper bits; pages that differ only in their tag bits occupy separate entries of one set.
- R3: Reset clears every valid bit, and an entry whose valid bit is clear never produces a hit.
- R4: A refill becomes visible to lookups in the cycle after it is presented; a lookup of the same page in the same cycle as the refill still sees the old contents and misses.
- R5: While the indexed set has an empty way, a refill fills an empty way, so WAYS distinct pages written into an empty set all remain resident.
- R6: A refill of a new page into a full set replaces exactly one resident entry, and the new page then hits.
- R7: The victim in a full set comes from a free-running shift register that never holds zero, so repeated evictions from one set do not always remove the same way.
- R8: A refill of a page that is already resident overwrites that entry in place with the new frame and evicts nothing else in the set.
- R9: A flush clears every valid bit in one cycle, and a refill presented in the same cycle as a flush is dropped.
- R10: `hit_cnt` and `miss_cnt` reset to zero, each advances by one for every lookup with that outcome, and a flush leaves them unchanged.
- R11: With WAYS=1, two pages with the same set bits evict each other; with SETS=1, WAYS pages with identical low bits are all resident at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request strobe |
| lk_vpn | input | VPN_W | Virtual page number to look up |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_miss | output | 1 | Lookup found no valid matching entry |
| lk_pfn | output | PFN_W | Frame number on a hit, zero otherwise |
| rf_valid | input | 1 | Refill strobe |
| rf_vpn | input | VPN_W | Page number being installed |
| rf_pfn | input | PFN_W | Frame number being installed |
| hit_cnt | output | CNT_W | Running count of hits |
| miss_cnt | output | CNT_W | Running count of misses |

## Verification
The hardest case to reach from the ports is the pseudo-random victim choice. The shift register is internal, so the bench cannot know which way will be chosen. Each trial therefore flushes, loads four known pages into one set, waits a different number of idle cycles, and refills a fifth page. The bench then looks up the four old pages to find the one that went missing. Because the empty-way-first rule places the four pages in a known order, the missing page identifies the evicted way. Across the trials the bench expects exactly one loss each time and more than one distinct way lost overall.

// File: rtl/tlb_rand_assoc.sv
module tlb_rand_assoc #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 16,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 32,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAPS = 8'hB8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             rf_valid,
  input  logic [VPN_W-1:0] rf_vpn,
  input  logic [PFN_W-1:0] rf_pfn,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] miss_cnt
);
  localparam int SB    = (SETS > 1) ? $clog2(SETS) : 0;
  localparam int SI_W  = (SETS > 1) ? SB : 1;
  localparam int TAG_W = VPN_W - SB;
  localparam int WI_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PFN_W-1:0] pfn_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [LFSR_W-1:0] lfsr_q;

  logic [SI_W-1:0]  lk_set, rf_set;
  logic [TAG_W-1:0] lk_tag, rf_tag;
  logic [WAYS-1:0]  lk_match;
  logic [WI_W-1:0]  rnd_way, victim;
  logic             rf_write;

  generate
    if (SETS > 1) begin : g_idx
      assign lk_set = lk_vpn[SB-1:0];
      assign rf_set = rf_vpn[SB-1:0];
      assign lk_tag = lk_vpn[VPN_W-1:SB];
      assign rf_tag = rf_vpn[VPN_W-1:SB];
    end else begin : g_noidx
      assign lk_set = '0;
      assign rf_set = '0;
      assign lk_tag = lk_vpn;
      assign rf_tag = rf_vpn;
    end

    if (WAYS > 1) begin : g_rnd
      assign rnd_way = lfsr_q[WI_W-1:0];
    end else begin : g_one
      assign rnd_way = '0;
    end
  endgenerate

  always_comb begin
    lk_match = '0;
    lk_pfn   = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      if (lk_match[w]) lk_pfn = pfn_q[lk_set][w];
    end
  end

  assign lk_hit   = lk_valid &&  (|lk_match);
  assign lk_miss  = lk_valid && !(|lk_match);
  assign rf_write = rf_valid && !flush;

  always_comb begin
    logic           same_any, free_any;
    logic [WI_W-1:0] same_way, free_way;
    same_any = 1'b0;
    free_any = 1'b0;
    same_way = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[rf_set][w] && (tag_q[rf_set][w] == rf_tag)) begin
        same_any = 1'b1;
        same_way = WI_W'(w);
      end
      if (!vld_q[rf_set][w]) begin
        free_any = 1'b1;
        free_way = WI_W'(w);
      end
    end
    victim = same_any ? same_way : (free_any ? free_way : rnd_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_W'(1);
    else        lfsr_q <= {lfsr_q[LFSR_W-2:0], ^(lfsr_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (flush) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (rf_valid) begin
      vld_q[rf_set][victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_write) begin
      tag_q[rf_set][victim] <= rf_tag;
      pfn_q[rf_set][victim] <= rf_pfn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_cnt  <= '0;
      miss_cnt <= '0;
    end else if (lk_valid) begin
      if (|lk_match) hit_cnt  <= hit_cnt + CNT_W'(1);
      else           miss_cnt <= miss_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tlb_rand_assoc_chk.sv
module tlb_rand_assoc_chk #(
  parameter int VPN_W  = 20,
  parameter int PFN_W  = 16,
  parameter int CNT_W  = 32,
  parameter int LFSR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              lk_valid,
  input logic [VPN_W-1:0]  lk_vpn,
  input logic              lk_hit,
  input logic              lk_miss,
  input logic [PFN_W-1:0]  lk_pfn,
  input logic              rf_valid,
  input logic [VPN_W-1:0]  rf_vpn,
  input logic [PFN_W-1:0]  rf_pfn,
  input logic [CNT_W-1:0]  hit_cnt,
  input logic [CNT_W-1:0]  miss_cnt,
  input logic [LFSR_W-1:0] lfsr_q
);
  // R1
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit ^ lk_miss));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  // R9
  flush_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !lk_hit);

  // R4
  refill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rf_valid && !flush) && lk_valid && (lk_vpn == $past(rf_vpn)))
      |-> (lk_hit && (lk_pfn == $past(rf_pfn))));

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R10
  hit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> (hit_cnt == $past(hit_cnt) + CNT_W'(1)) && $stable(miss_cnt));

  // R10
  miss_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |=> (miss_cnt == $past(miss_cnt) + CNT_W'(1)) && $stable(hit_cnt));
endmodule

bind tlb_rand_assoc tlb_rand_assoc_chk #(
  .VPN_W(VPN_W), .PFN_W(PFN_W), .CNT_W(CNT_W), .LFSR_W(LFSR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
  .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn),
  .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .lfsr_q(lfsr_q)
);

// File: tb/tlb_rand_assoc_tb.sv
`timescale 1ns/1ps
module tlb_rand_assoc_tb;
  localparam int VW = 8;
  localparam int PW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic flush = 1'b0, lk_valid = 1'b0, rf_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0, rf_vpn = '0;
  logic [PW-1:0] rf_pfn = '0;

  logic hit, miss, dm_hit, dm_miss, fa_hit, fa_miss;
  logic [PW-1:0] pfn, dm_pfn, fa_pfn;
  logic [CW-1:0] hc, mc, dm_hc, dm_mc, fa_hc, fa_mc;

  tlb_rand_assoc #(.VPN_W(VW), .PFN_W(PW), .SETS(4), .WAYS(4), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(hit), .lk_miss(miss), .lk_pfn(pfn), .rf_valid(rf_valid), .rf_vpn(rf_vpn),
    .rf_pfn(rf_pfn), .hit_cnt(hc), .miss_cnt(mc));

  tlb_rand_assoc #(.VPN_W(VW), .PFN_W(PW), .SETS(4), .WAYS(1), .CNT_W(CW)) u_dm (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(dm_hit), .lk_miss(dm_miss), .lk_pfn(dm_pfn), .rf_valid(rf_valid), .rf_vpn(rf_vpn),
    .rf_pfn(rf_pfn), .hit_cnt(dm_hc), .miss_cnt(dm_mc));

  tlb_rand_assoc #(.VPN_W(VW), .PFN_W(PW), .SETS(1), .WAYS(4), .CNT_W(CW)) u_fa (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_hit(fa_hit), .lk_miss(fa_miss), .lk_pfn(fa_pfn), .rf_valid(rf_valid), .rf_vpn(rf_vpn),
    .rf_pfn(rf_pfn), .hit_cnt(fa_hc), .miss_cnt(fa_mc));

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string rq, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] pf(logic [VW-1:0] v);
    return v ^ 8'hA5;
  endfunction

  task automatic cyc(bit lv, logic [VW-1:0] lvp, bit rv, logic [VW-1:0] rvp,
                     logic [PW-1:0] rp, bit fl);
    @(negedge clk);
    lk_valid = lv; lk_vpn = lvp; rf_valid = rv; rf_vpn = rvp; rf_pfn = rp; flush = fl;
    #1;
  endtask

  task automatic look(logic [VW-1:0] v);
    cyc(1'b1, v, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic fill(logic [VW-1:0] v, logic [PW-1:0] p);
    cyc(1'b0, '0, 1'b1, v, p, 1'b0);
  endtask

  task automatic idle();
    cyc(1'b0, '0, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic do_flush();
    cyc(1'b0, '0, 1'b0, '0, '0, 1'b1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [CW-1:0] hc0, mc0;
    logic [3:0] lost_mask;
    int hits;
    lost_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    // R10 reset values, R1 idle outputs quiet
    chk("R10 reset hit_cnt", hc, 0);
    chk("R10 reset miss_cnt", mc, 0);
    chk("R1 idle hit", hit, 0);
    chk("R1 idle miss", miss, 0);

    // R3: after reset every page misses
    for (int v = 0; v < 256; v++) begin
      look(VW'(v));
      chk("R3 empty miss", miss, 1);
      chk("R3 empty no hit", hit, 0);
    end
    idle();
    chk("R10 miss count after empty sweep", mc, 256);
    chk("R10 hit count after empty sweep", hc, 0);

    // R2/R5: tags 0..3 in every set, set = vpn[1:0], tag = vpn[7:2]
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 4; t++) fill(VW'(t * 4 + s), pf(VW'(t * 4 + s)));
    for (int v = 0; v < 256; v++) begin
      look(VW'(v));
      chk("R2 resident iff tag<4", hit, ((v >> 2) < 4) ? 1 : 0);
      if ((v >> 2) < 4) chk("R1 frame on hit", pfn, pf(VW'(v)));
    end
    idle();
    chk("R10 hit count after fill sweep", hc, 16);
    chk("R10 miss count after fill sweep", mc, 496);

    // R4: refill and lookup of the same page in one cycle
    cyc(1'b1, 8'h41, 1'b1, 8'h41, pf(8'h41), 1'b0);
    chk("R4 same-cycle lookup misses", miss, 1);
    look(8'h41);
    chk("R4 next-cycle hit", hit, 1);
    chk("R4 next-cycle frame", pfn, pf(8'h41));
    hits = 0;
    for (int t = 0; t < 4; t++) begin
      look(VW'(t * 4 + 1));
      hits += hit;
    end
    chk("R6 one old entry lost in set 1", hits, 3);

    // R8: overwrite of a resident page in set 2
    fill(8'h06, 8'h3C);
    look(8'h06);
    chk("R8 updated frame", pfn, 8'h3C);
    hits = 0;
    for (int t = 0; t < 4; t++) begin
      look(VW'(t * 4 + 2));
      hits += hit;
    end
    chk("R8 no eviction in set 2", hits, 4);

    // R9/R10: flush with simultaneous refill
    idle();
    hc0 = hc;
    mc0 = mc;
    cyc(1'b0, '0, 1'b1, 8'h33, pf(8'h33), 1'b1);
    idle();
    chk("R10 flush keeps hit_cnt", hc, hc0);
    chk("R10 flush keeps miss_cnt", mc, mc0);
    look(8'h33);
    chk("R9 refill dropped during flush", miss, 1);
    for (int v = 0; v < 256; v++) begin
      look(VW'(v));
      chk("R9 flushed entry misses", hit, 0);
    end

    // R5/R6/R7: repeated evictions from a full set 0
    for (int k = 0; k < 16; k++) begin
      do_flush();
      for (int t = 1; t <= 4; t++) fill(VW'(t * 4), pf(VW'(t * 4)));
      hits = 0;
      for (int t = 1; t <= 4; t++) begin
        look(VW'(t * 4));
        hits += hit;
      end
      chk("R5 empty ways filled first", hits, 4);
      for (int i = 0; i < k + (k * 7) % 13; i++) idle();
      fill(8'h14, pf(8'h14));
      look(8'h14);
      chk("R6 new page resident", hit, 1);
      hits = 0;
      for (int t = 1; t <= 4; t++) begin
        look(VW'(t * 4));
        hits += hit;
        if (!hit) lost_mask[t-1] = 1'b1;
      end
      chk("R6 exactly one eviction", hits, 3);
    end
    chk("R7 more than one way evicted", ($countones(lost_mask) >= 2) ? 1 : 0, 1);

    // R11: fully associative instance keeps four pages with equal low bits
    do_flush();
    for (int t = 1; t <= 4; t++) fill(VW'(t * 16), pf(VW'(t * 16)));
    for (int t = 1; t <= 4; t++) begin
      look(VW'(t * 16));
      chk("R11 fully associative hit", fa_hit, 1);
      chk("R11 fully associative frame", fa_pfn, pf(VW'(t * 16)));
    end

    // R11: direct-mapped instance, two pages in set 0 conflict
    do_flush();
    fill(8'h04, pf(8'h04));
    fill(8'h08, pf(8'h08));
    look(8'h04);
    chk("R11 direct-mapped evicted page misses", dm_miss, 1);
    chk("R11 four-way keeps both", hit, 1);
    look(8'h08);
    chk("R11 direct-mapped latest hits", dm_hit, 1);
    chk("R11 direct-mapped frame", dm_pfn, pf(8'h08));
    idle();
    summary();
  end
endmodule